// File: doc/BRIEF.md
# Masked General-Purpose I/O Port

This block is one eight-pin general-purpose I/O port with a small register interface. Each pin has a two-bit mode field that selects one of four behaviours: input only, push-pull output, open-drain output, or quasi-bidirectional. The port turns the mode field and an output data bit into three pad controls for each pin: an output enable, an output level and a weak pull-up enable.

Software updates the output data register through a protect mask, so bits whose mask bit is set keep their value whatever is written. A separate window of single-bit addresses writes one data bit at a time and is not subject to that mask. Pad levels pass through a two-stage synchronizer, and a per-pin input-disable bit forces the synchronized level low before it is read back. The reset mode of every pin is set by a configuration input that selects either all-input or all-quasi-bidirectional.

Register access uses a plain address, write-enable and write-data bus with a combinational read-data return. Writes take effect at the rising clock edge on which the write enable is high.

Top module: `mask_io_port`

## Requirements
- R1: A pin whose mode field is 00 (input) has its output enable and its pull-up enable both low.
- R2: A pin in mode 01 (push-pull) has its output enable high and its output level equal to its data bit.
- R3: A pin in mode 10 (open-drain) with data bit 0 is driven low (enable high, level 0). With data bit 1 it is released (enable low) and its pull-up is off.
- R4: A pin in mode 11 (quasi-bidirectional) with data bit 0 is driven low with its pull-up off. When the pin's data bit is 1 its pull-up is on. In the first cycle after the pin becomes quasi-bidirectional with data 1 (through a data write or a mode write), it is also driven high strongly. From the next cycle on the driver is released.
- R5: A write to offset 0x08 changes only the data bits whose protect-mask bit (offset 0x0C, bit n for pin n) is 0. Both registers read back their stored value.
- R6: A write to offset 0x40 + 4·n sets data bit n to write-data bit 0 regardless of the protect mask. A read of that address returns data bit n in bit 0.
- R7: A read of offset 0x10 returns the pad levels through a two-flop synchronizer. A pad change applied between edges becomes visible after the second following rising edge. Writes to 0x10 change nothing.
- R8: Bit 16+n of offset 0x04 is the input-disable bit of pin n. When it is set, bit n of the pin value read at 0x10 is 0. The register reads back in the same bit positions.
- R9: While reset is low, all mode fields become 00 if the configuration input is 0 and 11 if it is 1. The data register resets to all ones, and the mask and input-disable registers reset to zero.
- R10: Offset 0x00 holds pin n's mode in bits [2n+1:2n] and reads it back. Unmapped word offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgQuasiBoot | input | 1 | Reset mode select: 0 all input, 1 all quasi-bidirectional |
| busAddr | input | 8 | Register byte address |
| busWe | input | 1 | Write enable, sampled at the rising edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for busAddr |
| padIn | input | 8 | Pad input levels (asynchronous) |
| padOe | output | 8 | Per-pin output driver enable |
| padOut | output | 8 | Per-pin output level when enabled |
| padPullUp | output | 8 | Per-pin weak pull-up enable |

## Verification
If a mask bit is lost or the mode decode is wrong, the pad controls show it in the same cycle as the register edge: a protected pin toggles or an open-drain pin drives high. A stuck strong-high strobe in quasi mode shows up one cycle late, as a pin that keeps its driver enabled after the first cycle. A synchronizer of the wrong depth shifts the pin value readback by one edge, so the bench samples between the first and second edges after a pad change. A gating fault leaves a disabled pin reading high.

// File: rtl/mask_io_pkg.sv
package mask_io_pkg;

  localparam int OFF_MODE = 'h00;
  localparam int OFF_DIS  = 'h04;
  localparam int OFF_DATA = 'h08;
  localparam int OFF_MASK = 'h0C;
  localparam int OFF_PIN  = 'h10;
  localparam int OFF_BIT  = 'h40;
  localparam int DIS_LSB  = 16;

  localparam logic [1:0] MODE_IN = 2'b00;
  localparam logic [1:0] MODE_PP = 2'b01;
  localparam logic [1:0] MODE_OD = 2'b10;
  localparam logic [1:0] MODE_QB = 2'b11;

  typedef struct packed {
    logic wrMode;
    logic wrDis;
    logic wrData;
    logic wrMask;
    logic wrBit;
  } strobe_t;

  typedef enum logic [2:0] {
    RD_NONE, RD_MODE, RD_DIS, RD_DATA, RD_MASK, RD_PIN, RD_BIT
  } rdsel_t;

endpackage

// File: rtl/mask_io_ctrl.sv
module mask_io_ctrl
  import mask_io_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_PINS = 8,
  localparam int IDX_W   = $clog2(NUM_PINS)
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output strobe_t           strobes,
  output rdsel_t            rdSel,
  output logic [IDX_W-1:0]  bitIdx
);

  logic [ADDR_W-1:0] relAddr;
  logic              inBitWin;

  assign relAddr  = busAddr - ADDR_W'(OFF_BIT);
  assign inBitWin = (relAddr < ADDR_W'(4 * NUM_PINS)) && (relAddr[1:0] == 2'b00);
  assign bitIdx   = relAddr[IDX_W+1:2];

  always_comb begin
    rdSel = RD_NONE;
    if (inBitWin)                          rdSel = RD_BIT;
    else if (busAddr == ADDR_W'(OFF_MODE)) rdSel = RD_MODE;
    else if (busAddr == ADDR_W'(OFF_DIS))  rdSel = RD_DIS;
    else if (busAddr == ADDR_W'(OFF_DATA)) rdSel = RD_DATA;
    else if (busAddr == ADDR_W'(OFF_MASK)) rdSel = RD_MASK;
    else if (busAddr == ADDR_W'(OFF_PIN))  rdSel = RD_PIN;
  end

  always_comb begin
    strobes        = '0;
    strobes.wrMode = busWe && (rdSel == RD_MODE);
    strobes.wrDis  = busWe && (rdSel == RD_DIS);
    strobes.wrData = busWe && (rdSel == RD_DATA);
    strobes.wrMask = busWe && (rdSel == RD_MASK);
    strobes.wrBit  = busWe && (rdSel == RD_BIT);
  end

endmodule

// File: rtl/mask_io_datapath.sv
module mask_io_datapath
  import mask_io_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(NUM_PINS),
  localparam int MODE_W  = 2 * NUM_PINS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgQuasiBoot,
  input  strobe_t             strobes,
  input  rdsel_t              rdSel,
  input  logic [IDX_W-1:0]    bitIdx,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [DATA_W-1:0]   busRdata,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padPullUp
);

  logic [MODE_W-1:0]   modeQ, modeNext;
  logic [NUM_PINS-1:0] dataQ, dataNext;
  logic [NUM_PINS-1:0] maskQ, disQ, kickQ, kickNext;
  logic [NUM_PINS-1:0] syncA, syncB, pinVal;
  logic [NUM_PINS-1:0] quasiHiNow, quasiHiNext;

  always_comb begin
    modeNext = strobes.wrMode ? busWdata[MODE_W-1:0] : modeQ;
    dataNext = dataQ;
    if (strobes.wrData)
      dataNext = (dataQ & maskQ) | (busWdata[NUM_PINS-1:0] & ~maskQ);
    if (strobes.wrBit)
      dataNext[bitIdx] = busWdata[0];
  end

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : gPin
      logic [1:0] pinMode;
      assign pinMode        = modeQ[2*i +: 2];
      assign quasiHiNow[i]  = (pinMode == MODE_QB) && dataQ[i];
      assign quasiHiNext[i] = (modeNext[2*i +: 2] == MODE_QB) && dataNext[i];
      assign kickNext[i]    = quasiHiNext[i] && !quasiHiNow[i];

      always_comb begin
        padOe[i]     = 1'b0;
        padOut[i]    = 1'b0;
        padPullUp[i] = 1'b0;
        case (pinMode)
          MODE_PP: begin
            padOe[i]  = 1'b1;
            padOut[i] = dataQ[i];
          end
          MODE_OD: padOe[i] = !dataQ[i];
          MODE_QB: begin
            padOe[i]     = !dataQ[i] || kickQ[i];
            padOut[i]    = dataQ[i];
            padPullUp[i] = dataQ[i];
          end
          default: ;
        endcase
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= {MODE_W{cfgQuasiBoot}};
      dataQ <= '1;
      maskQ <= '0;
      disQ  <= '0;
      kickQ <= '0;
      syncA <= '0;
      syncB <= '0;
    end else begin
      modeQ <= modeNext;
      dataQ <= dataNext;
      kickQ <= kickNext;
      syncA <= padIn;
      syncB <= syncA;
      if (strobes.wrMask) maskQ <= busWdata[NUM_PINS-1:0];
      if (strobes.wrDis)  disQ  <= busWdata[DIS_LSB +: NUM_PINS];
    end
  end

  assign pinVal = syncB & ~disQ;

  always_comb begin
    busRdata = '0;
    case (rdSel)
      RD_MODE: busRdata[MODE_W-1:0]           = modeQ;
      RD_DIS:  busRdata[DIS_LSB +: NUM_PINS]  = disQ;
      RD_DATA: busRdata[NUM_PINS-1:0]         = dataQ;
      RD_MASK: busRdata[NUM_PINS-1:0]         = maskQ;
      RD_PIN:  busRdata[NUM_PINS-1:0]         = pinVal;
      RD_BIT:  busRdata[0]                    = dataQ[bitIdx];
      default: ;
    endcase
  end

  logic unusedWdataBits;
  assign unusedWdataBits = ^busWdata;

endmodule

// File: rtl/mask_io_port.sv
module mask_io_port
  import mask_io_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgQuasiBoot,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWe,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padPullUp
);

  localparam int IDX_W = $clog2(NUM_PINS);

  strobe_t          strobes;
  rdsel_t           rdSel;
  logic [IDX_W-1:0] bitIdx;

  mask_io_ctrl #(.ADDR_W(ADDR_W), .NUM_PINS(NUM_PINS)) uCtrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strobes (strobes),
    .rdSel   (rdSel),
    .bitIdx  (bitIdx)
  );

  mask_io_datapath #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .cfgQuasiBoot (cfgQuasiBoot),
    .strobes      (strobes),
    .rdSel        (rdSel),
    .bitIdx       (bitIdx),
    .busWdata     (busWdata),
    .padIn        (padIn),
    .busRdata     (busRdata),
    .padOe        (padOe),
    .padOut       (padOut),
    .padPullUp    (padPullUp)
  );

endmodule

// File: rtl/mask_io_checker.sv
module mask_io_checker #(
  parameter int ADDR_W   = 8,
  parameter int NUM_PINS = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [ADDR_W-1:0]     busAddr,
  input logic                  busWe,
  input logic [NUM_PINS-1:0]   padIn,
  input logic [NUM_PINS-1:0]   padOe,
  input logic [NUM_PINS-1:0]   padOut,
  input logic [NUM_PINS-1:0]   padPullUp,
  input logic [2*NUM_PINS-1:0] modeQ,
  input logic [NUM_PINS-1:0]   dataQ,
  input logic [NUM_PINS-1:0]   maskQ,
  input logic [NUM_PINS-1:0]   disQ,
  input logic [NUM_PINS-1:0]   pinVal
);

  logic [NUM_PINS-1:0] isIn, isOd;
  logic [1:0]          sinceRst;
  logic                dataWr;

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      isIn[i] = modeQ[2*i +: 2] == 2'b00;
      isOd[i] = modeQ[2*i +: 2] == 2'b10;
    end
  end

  assign dataWr = busWe && (busAddr == ADDR_W'('h08));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  p_input_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    ((padOe | padPullUp) & isIn) == '0);

  p_od_no_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & padOut & isOd) == '0);

  p_pullup_not_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    (padPullUp & padOe & ~padOut) == '0);

  p_kick_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((padOe & padOut & padPullUp) != '0) |=>
    ((padOe & padOut & padPullUp & $past(padOe & padOut & padPullUp)) == '0));

  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    dataWr |=> ((dataQ & $past(maskQ)) == ($past(dataQ) & $past(maskQ))));

  p_sync_delay_r7: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2) |-> (pinVal == ($past(padIn, 2) & ~disQ)));

  p_disable_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pinVal & disQ) == '0);

endmodule

bind mask_io_port mask_io_checker #(.ADDR_W(ADDR_W), .NUM_PINS(NUM_PINS)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWe     (busWe),
  .padIn     (padIn),
  .padOe     (padOe),
  .padOut    (padOut),
  .padPullUp (padPullUp),
  .modeQ     (uDp.modeQ),
  .dataQ     (uDp.dataQ),
  .maskQ     (uDp.maskQ),
  .disQ      (uDp.disQ),
  .pinVal    (uDp.pinVal)
);

// File: tb/mask_io_port_test.sv
`timescale 1ns/1ps
module mask_io_port_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgQuasiBoot = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0]  padIn = '0;
  logic [7:0]  padOe, padOut, padPullUp;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mask_io_port uut (
    .clk(clk), .rstN(rstN), .cfgQuasiBoot(cfgQuasiBoot),
    .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata),
    .padIn(padIn), .padOe(padOe), .padOut(padOut), .padPullUp(padPullUp)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #0.5;
    d = busRdata;
  endtask

  task automatic doReset(input logic cfg);
    @(negedge clk);
    rstN = 1'b0; cfgQuasiBoot = cfg;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic pads(input string req, input logic [7:0] oe, input logic [7:0] outv, input logic [7:0] pu);
    chk(req, "padOe", padOe, oe);
    chk(req, "padOut", padOut & padOe, outv);
    chk(req, "padPullUp", padPullUp, pu);
  endtask

  task automatic testResetInput();
    logic [31:0] v;
    doReset(1'b0);
    busRead('h00, v); chk("R9", "mode reset input", v, 32'h0);
    busRead('h08, v); chk("R9", "data reset", v, 32'hFF);
    busRead('h0C, v); chk("R9", "mask reset", v, 32'h0);
    busRead('h04, v); chk("R9", "disable reset", v, 32'h0);
    pads("R1", 8'h00, 8'h00, 8'h00);
  endtask

  task automatic testPushPull();
    busWrite('h00, 32'h5555);
    busWrite('h08, 32'hA5);
    pads("R2", 8'hFF, 8'hA5, 8'h00);
  endtask

  task automatic testMask();
    logic [31:0] v;
    busWrite('h0C, 32'h0F);
    busWrite('h08, 32'h5A);
    busRead('h08, v); chk("R5", "masked data", v, 32'h55);
    busRead('h0C, v); chk("R5", "mask readback", v, 32'h0F);
    pads("R5", 8'hFF, 8'h55, 8'h00);
  endtask

  task automatic testBitWrite();
    logic [31:0] v;
    busWrite('h44, 32'h1);
    busRead('h08, v); chk("R6", "bit1 set past mask", v, 32'h57);
    busWrite('h40, 32'h0);
    busRead('h08, v); chk("R6", "bit0 clear past mask", v, 32'h56);
    busRead('h44, v); chk("R6", "bit1 readback", v, 32'h1);
    busRead('h40, v); chk("R6", "bit0 readback", v, 32'h0);
    pads("R6", 8'hFF, 8'h56, 8'h00);
  endtask

  task automatic testOpenDrain();
    busWrite('h0C, 32'h0);
    busWrite('h00, 32'hAAAA);
    busWrite('h08, 32'h0F);
    pads("R3", 8'hF0, 8'h00, 8'h00);
  endtask

  task automatic testMixed();
    logic [31:0] v;
    busWrite('h00, 32'h00E4);
    busRead('h00, v); chk("R10", "mode readback", v, 32'hE4);
    pads("R4", 8'h0A, 8'h0A, 8'h08);
    @(negedge clk);
    pads("R1", 8'h02, 8'h02, 8'h08);
  endtask

  task automatic testSyncGate();
    logic [31:0] v;
    @(negedge clk);
    padIn = 8'h3C;
    @(posedge clk); #1;
    busRead('h10, v); chk("R7", "pin after one edge", v, 32'h00);
    @(posedge clk); #1;
    busRead('h10, v); chk("R7", "pin after two edges", v, 32'h3C);
    busWrite('h04, 32'h000F_0000);
    busRead('h04, v); chk("R8", "disable readback", v, 32'h000F_0000);
    busRead('h10, v); chk("R8", "gated pin value", v, 32'h30);
    busWrite('h10, 32'hFFFF_FFFF);
    busRead('h10, v); chk("R7", "pin after ignored write", v, 32'h30);
    busRead('h08, v); chk("R7", "data after write to 0x10", v, 32'h0F);
    busRead('h00, v); chk("R7", "mode after write to 0x10", v, 32'hE4);
    busRead('h30, v); chk("R10", "unmapped read", v, 32'h0);
  endtask

  task automatic testQuasi();
    logic [31:0] v;
    doReset(1'b1);
    busRead('h00, v); chk("R9", "mode reset quasi", v, 32'hFFFF);
    pads("R9", 8'h00, 8'h00, 8'hFF);
    busWrite('h08, 32'h0F);
    pads("R4", 8'hF0, 8'h00, 8'h0F);
    busWrite('h08, 32'hFF);
    pads("R4", 8'hF0, 8'hF0, 8'hFF);
    @(negedge clk);
    pads("R4", 8'h00, 8'h00, 8'hFF);
  endtask

  initial begin
    testResetInput();
    testPushPull();
    testMask();
    testBitWrite();
    testOpenDrain();
    testMixed();
    testSyncGate();
    testQuasi();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule